// File: doc/BRIEF.md
# Chained Order-Pair Prefetch Controller

This block keeps the order pair of a selector-style I/O channel: a control word and an address word. It holds one active pair, which drives the running block transfer, and one shadow pair that is filled ahead of time. A start pulse loads the I/O program counter. The controller then reads the control word and the address word from consecutive memory locations, and the transfer begins. Each word read moves the program counter on by one, so each pair moves it by two.

Bit `CHAIN_POS` of the active control word asks for chaining. When it is set, the controller reads the next pair into the shadow registers while the current block runs, whenever the shared memory port grants it access. When the block ends, the controller first writes the residue word count into the memory location that held the active address word. On a chained end it then copies the shadow pair into the active registers without a fetch sequence, and the out-transfer flag stays high. If the shadow pair is still incomplete, the controller waits for it to finish. On an unchained end the flag drops and a normal fetch of the next pair follows.

The memory port is a plain request/grant port. An access completes in the cycle it is granted, and read data is taken in that same cycle. The device handshake and the port's internal timing are outside this block.

Top module: `order_chain_ctrl`

## Requirements
- R1: After reset the out-transfer flag, the memory request, the program counter and both active words are 0.
- R2: A start pulse is accepted only while the controller is idle. It loads the program counter from `start_pc_i`. Every granted read of an order word then adds 1 to the program counter, modulo 2^AW, so each pair adds 2. A start pulse at any other time has no effect.
- R3: The memory request stays high until it is granted, and nothing advances without a grant. A read takes `mem_rdata_i` in its grant cycle. When there is no request, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` are 0.
- R4: In a normal fetch the control word is read at the program counter and the address word at the next location. The out-transfer flag rises in the cycle after the address word's grant.
- R5: While a block runs with bit `CHAIN_POS` of the active control word at 1, the controller requests reads at the program counter until it holds both words of the next pair, then stops. With that bit at 0 it makes no request during the block.
- R6: `order_done_i` is acted on only while a block runs, and it captures `residue_i`. The next access is then a write of that residue to the location from which the active address word was read. At any other time `order_done_i` is ignored.
- R7: On a chained end with the shadow pair complete, the shadow pair becomes active in the cycle after the residue write's grant. The block resumes, and the out-transfer flag stays 1.
- R8: On a chained end with the shadow pair incomplete, the controller keeps prefetching after the residue write. It loads the pair in the cycle after it becomes complete, without falling back to a normal fetch.
- R9: On an unchained end the out-transfer flag is 0 in the cycle after the residue write's grant, and a normal fetch starts at the current program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an order program (idle only) |
| start_pc_i | input | AW | Program counter value loaded at start |
| order_done_i | input | 1 | Current block has ended |
| residue_i | input | DW | Residue word count at block end |
| mem_gnt_i | input | 1 | Memory port grant; the access completes this cycle |
| mem_rdata_i | input | DW | Read data, valid in the grant cycle |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | DW | Write data (residue) |
| act_ctrl_o | output | DW | Active control word |
| act_addr_o | output | DW | Active address word |
| pc_o | output | AW | I/O program counter |
| out_xfer_o | output | 1 | Out-transfer condition |

## Verification
The bench builds the block with AW=8, DW=16 and CHAIN_POS=0, against a 256-word memory. The 8-bit program counter lets a long random-grant run wrap the program counter and residue addresses past the top of memory. It also lets residue writes land on words that later become orders, so chained and unchained ends mix without planning. Holding the grant low at the moment a chained block ends forces the wait-for-prefetch path, and a constant grant forces the immediate swap.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_FCTL = 3'd1,
    SQ_FADR = 3'd2,
    SQ_RUN  = 3'd3,
    SQ_WBK  = 3'd4,
    SQ_WAIT = 3'd5
  } seq_t;

  // next word location, wrapped to an aw-bit space
  function automatic int unsigned step_word(int unsigned a, int unsigned aw);
    return (a + 1) & ((1 << aw) - 1);
  endfunction

  // chaining flag of a control word
  function automatic logic chain_of(logic [63:0] w, int unsigned pos);
    return w[pos];
  endfunction

  // sequencer states that own the memory port
  function automatic logic seq_owns_port(seq_t s);
    return (s == SQ_FCTL) || (s == SQ_FADR) || (s == SQ_WBK);
  endfunction

endpackage

// File: rtl/ocp_seq.sv
module ocp_seq
  import ocp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  input  logic gnt_i,
  input  logic chain_i,
  input  logic pf_full_i,
  output seq_t state_o,
  output logic rd_ctl_o,
  output logic rd_adr_o,
  output logic run_done_o,
  output logic wb_done_o,
  output logic swap_o
);

  seq_t st, st_nx;

  assign rd_ctl_o   = (st == SQ_FCTL) && gnt_i;
  assign rd_adr_o   = (st == SQ_FADR) && gnt_i;
  assign run_done_o = (st == SQ_RUN) && done_i;
  assign wb_done_o  = (st == SQ_WBK) && gnt_i;
  assign swap_o     = (wb_done_o && chain_i && pf_full_i) ||
                      ((st == SQ_WAIT) && pf_full_i);
  assign state_o    = st;

  always_comb begin
    st_nx = st;
    unique case (st)
      SQ_IDLE: if (start_i) st_nx = SQ_FCTL;
      SQ_FCTL: if (gnt_i) st_nx = SQ_FADR;
      SQ_FADR: if (gnt_i) st_nx = SQ_RUN;
      SQ_RUN:  if (done_i) st_nx = SQ_WBK;
      SQ_WBK: begin
        if (gnt_i) begin
          if (!chain_i)       st_nx = SQ_FCTL;
          else if (pf_full_i) st_nx = SQ_RUN;
          else                st_nx = SQ_WAIT;
        end
      end
      SQ_WAIT: if (pf_full_i) st_nx = SQ_RUN;
      default: st_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SQ_IDLE;
    else        st <= st_nx;
  end

endmodule

// File: rtl/ocp_prefetch.sv
module ocp_prefetch #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          grant_i,
  input  logic          clear_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [AW-1:0] pc_i,
  output logic          req_o,
  output logic          rd_o,
  output logic          full_o,
  output logic [DW-1:0] buf_ctrl_o,
  output logic [DW-1:0] buf_addr_o,
  output logic [AW-1:0] buf_loc_o
);

  logic second_q;
  logic full_q;

  assign req_o  = arm_i && !full_q;
  assign rd_o   = req_o && grant_i;
  assign full_o = full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q   <= 1'b0;
      full_q     <= 1'b0;
      buf_ctrl_o <= '0;
      buf_addr_o <= '0;
      buf_loc_o  <= '0;
    end else if (clear_i) begin
      second_q <= 1'b0;
      full_q   <= 1'b0;
    end else if (rd_o) begin
      if (!second_q) begin
        buf_ctrl_o <= rdata_i;
        second_q   <= 1'b1;
      end else begin
        buf_addr_o <= rdata_i;
        buf_loc_o  <= pc_i;
        second_q   <= 1'b0;
        full_q     <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ocp_port.sv
module ocp_port
  import ocp_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  seq_t          state_i,
  input  logic          pf_req_i,
  input  logic          gnt_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] loc_i,
  input  logic [DW-1:0] resid_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          pf_grant_o
);

  logic own;
  assign own = seq_owns_port(state_i);

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    if (state_i == SQ_WBK) begin
      mem_req_o   = 1'b1;
      mem_we_o    = 1'b1;
      mem_addr_o  = loc_i;
      mem_wdata_o = resid_i;
    end else if (own || pf_req_i) begin
      mem_req_o  = 1'b1;
      mem_addr_o = pc_i;
    end
  end

  assign pf_grant_o = gnt_i && !own;

endmodule

// File: rtl/order_chain_ctrl.sv
module order_chain_ctrl
  import ocp_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int CHAIN_POS = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_pc_i,
  input  logic          order_done_i,
  input  logic [DW-1:0] residue_i,
  input  logic          mem_gnt_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [DW-1:0] act_ctrl_o,
  output logic [DW-1:0] act_addr_o,
  output logic [AW-1:0] pc_o,
  output logic          out_xfer_o
);

  // named internal events, also used by the checker
  seq_t          seq_st;
  logic          ev_rd_ctl, ev_rd_adr, ev_run_done, ev_wb_done, ev_swap;
  logic          pf_req, pf_rd, pf_full, pf_grant, pf_arm;
  logic          ev_word_rd;
  logic          chain_act;
  logic [DW-1:0] buf_ctrl_w, buf_addr_w;
  logic [AW-1:0] buf_loc_w;
  logic [AW-1:0] pc_q, aw_loc_q;
  logic [DW-1:0] resid_q;

  assign chain_act  = chain_of(64'(act_ctrl_o), CHAIN_POS);
  assign pf_arm     = chain_act && ((seq_st == SQ_RUN) || (seq_st == SQ_WAIT));
  assign ev_word_rd = ev_rd_ctl || ev_rd_adr || pf_rd;
  assign pc_o       = pc_q;

  ocp_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .done_i     (order_done_i),
    .gnt_i      (mem_gnt_i),
    .chain_i    (chain_act),
    .pf_full_i  (pf_full),
    .state_o    (seq_st),
    .rd_ctl_o   (ev_rd_ctl),
    .rd_adr_o   (ev_rd_adr),
    .run_done_o (ev_run_done),
    .wb_done_o  (ev_wb_done),
    .swap_o     (ev_swap)
  );

  ocp_prefetch #(.AW(AW), .DW(DW)) u_pf (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (pf_arm),
    .grant_i    (pf_grant),
    .clear_i    (ev_swap),
    .rdata_i    (mem_rdata_i),
    .pc_i       (pc_q),
    .req_o      (pf_req),
    .rd_o       (pf_rd),
    .full_o     (pf_full),
    .buf_ctrl_o (buf_ctrl_w),
    .buf_addr_o (buf_addr_w),
    .buf_loc_o  (buf_loc_w)
  );

  ocp_port #(.AW(AW), .DW(DW)) u_port (
    .state_i     (seq_st),
    .pf_req_i    (pf_req),
    .gnt_i       (mem_gnt_i),
    .pc_i        (pc_q),
    .loc_i       (aw_loc_q),
    .resid_i     (resid_q),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .pf_grant_o  (pf_grant)
  );

  // program counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc_q <= '0;
    else if ((seq_st == SQ_IDLE) && start_i)
      pc_q <= start_pc_i;
    else if (ev_word_rd)
      pc_q <= AW'(step_word(32'(pc_q), AW));
  end

  // active order pair and the location of its address word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ctrl_o <= '0;
      act_addr_o <= '0;
      aw_loc_q   <= '0;
    end else if (ev_swap) begin
      act_ctrl_o <= buf_ctrl_w;
      act_addr_o <= buf_addr_w;
      aw_loc_q   <= buf_loc_w;
    end else if (ev_rd_ctl) begin
      act_ctrl_o <= mem_rdata_i;
    end else if (ev_rd_adr) begin
      act_addr_o <= mem_rdata_i;
      aw_loc_q   <= pc_q;
    end
  end

  // residue captured at block end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           resid_q <= '0;
    else if (ev_run_done) resid_q <= residue_i;
  end

  // out-transfer condition
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         out_xfer_o <= 1'b0;
    else if (ev_rd_adr)                 out_xfer_o <= 1'b1;
    else if (ev_wb_done && !chain_act)  out_xfer_o <= 1'b0;
  end

endmodule

// File: rtl/ocp_checker.sv
module ocp_checker #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_word_rd,
  input logic          ev_wb_done,
  input logic          ev_swap,
  input logic          chain_act,
  input logic          pf_rd,
  input logic          pf_full,
  input logic [DW-1:0] buf_ctrl_w,
  input logic [AW-1:0] pc_o,
  input logic [DW-1:0] act_ctrl_o,
  input logic          out_xfer_o,
  input logic          mem_we_o,
  input logic          mem_req_o
);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_word_rd |=> pc_o == AW'($past(pc_o) + 1'b1));

  // R7
  swap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_swap |=> act_ctrl_o == $past(buf_ctrl_w));

  // R7
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wb_done && chain_act) |=> out_xfer_o);

  // R9
  unchain_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wb_done && !chain_act) |=> !out_xfer_o);

  // R5
  pf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_rd |-> chain_act && !pf_full);

  // R3
  port_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_req_o && !pf_rd);

endmodule

bind order_chain_ctrl ocp_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_word_rd (ev_word_rd),
  .ev_wb_done (ev_wb_done),
  .ev_swap    (ev_swap),
  .chain_act  (chain_act),
  .pf_rd      (pf_rd),
  .pf_full    (pf_full),
  .buf_ctrl_w (buf_ctrl_w),
  .pc_o       (pc_o),
  .act_ctrl_o (act_ctrl_o),
  .out_xfer_o (out_xfer_o),
  .mem_we_o   (mem_we_o),
  .mem_req_o  (mem_req_o)
);

// File: tb/sim_order_chain_ctrl.sv
`timescale 1ns/1ps
module sim_order_chain_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, order_done_i = 0, mem_gnt_i = 1;
  logic [AW-1:0] start_pc_i = '0;
  logic [DW-1:0] residue_i = '0;
  logic [DW-1:0] mem_rdata_i;
  logic mem_req_o, mem_we_o, out_xfer_o;
  logic [AW-1:0] mem_addr_o, pc_o;
  logic [DW-1:0] mem_wdata_o, act_ctrl_o, act_addr_o;

  logic [DW-1:0] mem [256];
  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  order_chain_ctrl #(.AW(AW), .DW(DW), .CHAIN_POS(0)) u0 (.*);

  assign mem_rdata_i = mem[mem_addr_o];

  always @(posedge clk)
    if (mem_req_o && mem_we_o && mem_gnt_i) mem[mem_addr_o] <= mem_wdata_o;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: 0 idle, 1 ctrl read, 2 addr read, 3 run, 4 residue write, 5 wait
  int m_st, m_pc, m_ctrl, m_addr, m_loc, m_res, m_bc, m_ba, m_bloc, m_pfn, m_ox;

  function automatic bit m_chain();
    return m_ctrl[0];
  endfunction

  function automatic bit m_pf_on();
    return m_chain() && (m_st == 3 || m_st == 5) && m_pfn < 2;
  endfunction

  task automatic m_pf_step();
    if (m_pfn == 0) m_bc = mem[m_pc];
    else begin m_ba = mem[m_pc]; m_bloc = m_pc; end
    m_pfn++;
    m_pc = (m_pc + 1) % 256;
  endtask

  task automatic m_swap();
    m_ctrl = m_bc; m_addr = m_ba; m_loc = m_bloc; m_pfn = 0; m_st = 3;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_pc = 0; m_ctrl = 0; m_addr = 0; m_loc = 0; m_res = 0;
      m_bc = 0; m_ba = 0; m_bloc = 0; m_pfn = 0; m_ox = 0;
    end else begin
      case (m_st)
        0: if (start_i) begin m_pc = start_pc_i; m_st = 1; end
        1: if (mem_gnt_i) begin m_ctrl = mem[m_pc]; m_pc = (m_pc + 1) % 256; m_st = 2; end
        2: if (mem_gnt_i) begin
             m_addr = mem[m_pc]; m_loc = m_pc; m_pc = (m_pc + 1) % 256; m_st = 3; m_ox = 1;
           end
        3: begin
             if (m_pf_on() && mem_gnt_i) m_pf_step();
             if (order_done_i) begin m_res = residue_i; m_st = 4; end
           end
        4: if (mem_gnt_i) begin
             if (!m_chain()) begin m_ox = 0; m_st = 1; end
             else if (m_pfn == 2) m_swap();
             else m_st = 5;
           end
        5: if (m_pfn == 2) m_swap();
           else if (m_pf_on() && mem_gnt_i) m_pf_step();
        default: m_st = 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done_flag) begin
      int e_req, e_we, e_addr, e_wd;
      e_req = 0; e_we = 0; e_addr = 0; e_wd = 0;
      if (m_st == 4) begin e_req = 1; e_we = 1; e_addr = m_loc; e_wd = m_res; end
      else if (m_st == 1 || m_st == 2 || m_pf_on()) begin e_req = 1; e_addr = m_pc; end
      chk("R3 mem_req", mem_req_o, e_req);
      chk("R6 mem_we", mem_we_o, e_we);
      chk("R3 mem_addr", mem_addr_o, e_addr);
      chk("R6 mem_wdata", mem_wdata_o, e_wd);
      chk("R2 pc", pc_o, m_pc);
      chk("R7 act_ctrl", act_ctrl_o, m_ctrl);
      chk("R7 act_addr", act_addr_o, m_addr);
      chk("R4 out_xfer", out_xfer_o, m_ox);
    end
  end

  task automatic wait_run();
    @(negedge clk);
    while (m_st != 3) @(negedge clk);
  endtask

  initial begin
    int lfsr;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h10] = 16'h0001; mem[8'h11] = 16'h0080;
    mem[8'h12] = 16'h0000; mem[8'h13] = 16'h0090;
    mem[8'h14] = 16'h0001; mem[8'h15] = 16'h00A0;
    mem[8'h16] = 16'h0001; mem[8'h17] = 16'h00B0;
    mem[8'h18] = 16'h0000; mem[8'h19] = 16'h00C0;
    repeat (3) @(negedge clk);
    chk("R1 pc", pc_o, 0);
    chk("R1 out_xfer", out_xfer_o, 0);
    chk("R1 mem_req", mem_req_o, 0);
    chk("R1 act_ctrl", act_ctrl_o, 0);
    rst_n = 1;
    @(negedge clk); order_done_i = 1; residue_i = 16'h7777;
    @(negedge clk); order_done_i = 0;
    chk("R6 done ignored when idle", mem_req_o, 0);
    start_i = 1; start_pc_i = 8'h10;
    @(negedge clk); start_i = 0;
    // chained block, shadow pair complete at end
    wait_run();
    repeat (6) @(negedge clk);
    chk("R5 prefetch stops when full", mem_req_o, 0);
    chk("R2 pc after pair and prefetch", pc_o, 8'h14);
    order_done_i = 1; residue_i = 16'h0F01;
    @(negedge clk); order_done_i = 0;
    @(negedge clk);
    chk("R7 swapped addr", act_addr_o, 16'h0090);
    chk("R7 out_xfer held", out_xfer_o, 1);
    chk("R6 residue stored", mem[8'h11], 16'h0F01);
    // unchained block
    repeat (3) @(negedge clk);
    chk("R5 no prefetch unchained", mem_req_o, 0);
    start_i = 1; start_pc_i = 8'h40;
    @(negedge clk); start_i = 0;
    chk("R2 start ignored when busy", pc_o, 8'h14);
    order_done_i = 1; residue_i = 16'h0F02;
    @(negedge clk); order_done_i = 0;
    @(negedge clk);
    chk("R9 out_xfer dropped", out_xfer_o, 0);
    wait_run();
    chk("R9 normal fetch addr", act_addr_o, 16'h00A0);
    chk("R6 residue stored", mem[8'h13], 16'h0F02);
    // chained block ending before prefetch completes
    mem_gnt_i = 0; order_done_i = 1; residue_i = 16'h0F03;
    @(negedge clk); order_done_i = 0; mem_gnt_i = 1;
    @(negedge clk);
    chk("R8 waiting keeps out_xfer", out_xfer_o, 1);
    wait_run();
    chk("R8 swap after late prefetch", act_addr_o, 16'h00B0);
    chk("R6 residue stored", mem[8'h15], 16'h0F03);
    // random grant phase
    lfsr = 32'h1ACE;
    for (int c = 0; c < 3000; c++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      mem_gnt_i = lfsr[3] | lfsr[7];
      order_done_i = (c % 23 == 5);
      residue_i = DW'(c);
      @(negedge clk);
    end
    order_done_i = 0; mem_gnt_i = 1;
    repeat (20) @(negedge clk);
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    done_flag = 1;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule